// File: doc/BRIEF.md
# Windowed Page Mapper with Run Remap

This block maps a 16 KiB window of a 16-bit CPU address space onto a 24-bit physical space. The window starts at 0x8000 and ends at 0xBFFF. It is cut into 64 pages of 256 bytes. Each page has its own 16-bit map entry, and that entry supplies physical address bits 23..8. The low byte of the address is carried through untouched. Addresses outside the window leave zero-extended and otherwise unchanged.

Software reaches the map through a byte-wide write port. It can load any single byte of any entry. It can also use a run-remap control. One trigger write rewrites a programmed number of leading entries with consecutive physical pages, so a whole region can be flipped in one access. The run writes one entry per clock and raises a busy flag while it runs.

Translations travel through a one-deep valid/ready stage. An address is accepted whenever the output register is empty or is being drained in the same cycle. A result that is not taken stays valid and stable until `pa_ready` is high.

Top module: `bank_mapper`

## Requirements
- R1: After reset every entry maps its page to itself: entry p holds 0x0080+p, so 0x8000 translates to 0x008000 and 0xBF12 to 0x00BF12. After reset `bulk_busy` and `pa_valid` are low.
- R2: An address in 0x8000..0xBFFF uses page index = address bits 13..8. The result is {entry, address bits 7..0}.
- R3: An address outside the window leaves as {8'h00, address}.
- R4: A write at offset 2p (p < 64) sets bits 7..0 of entry p, which become physical bits 15..8. A write at offset 2p+1 sets bits 15..8 of entry p, which become physical bits 23..16. Each write changes only the addressed byte.
- R5: A write to offset 0x81 starts a run. The data of that write is page bits 7..0 of the start page. The byte last written to offset 0x82 is page bits 15..8. With a run length c, entry k (k < c) receives start+k modulo 2^16, and entries k >= c are untouched. Writes to offset 0x80 have no effect.
- R6: The run length is taken from bits 5..0 of the byte written to offset 0x83. The upper two bits are ignored.
- R7: A trigger with a run length of 0 changes no entry and does not raise `bulk_busy`.
- R8: `bulk_busy` rises in the cycle after the trigger and stays high for exactly c cycles. A translation of a page not yet rewritten returns its old value.
- R9: While `bulk_busy` is high, every register write is ignored. This includes entry writes, run-length writes and further triggers.
- R10: Several entries may hold the same physical page, and each translates to it.
- R11: A translation is accepted when `xl_valid` and `xl_ready` are both high, with `xl_ready` = !`pa_valid` or `pa_ready`. Its result is valid in the next cycle. A result that is not taken stays valid with `pa_addr` held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| bulk_busy | output | 1 | Run remap in progress |
| xl_valid | input | 1 | CPU address valid |
| xl_ready | output | 1 | CPU address can be accepted |
| xl_addr | input | 16 | CPU address |
| pa_valid | output | 1 | Physical address valid |
| pa_ready | input | 1 | Consumer takes the physical address |
| pa_addr | output | 24 | Physical address |

## Verification
A translated address is due one cycle after its handshake. It is compared when the consumer takes it, in the order the addresses were accepted, so any stall only delays the comparison. A run of length c is timed from the trigger edge: `bulk_busy` must be high at the next falling edge and must fall exactly c rising edges after the trigger. Entries are compared only after the run ends, apart from one translation made mid-run that must still see its page's old value. Register writes take effect at the edge that samples them, so every check that depends on a write is placed one cycle or more after it.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int CPU_AW = 16;
  localparam int OFS_W  = 8;
  localparam int PAGE_W = 16;
  localparam int PA_W   = PAGE_W + OFS_W;

  typedef logic [PAGE_W-1:0] page_t;

  typedef enum logic [1:0] {
    CTL_BASE_LO = 2'd0,
    CTL_BASE_HI = 2'd1,
    CTL_HIGH    = 2'd2,
    CTL_COUNT   = 2'd3
  } ctl_sel_e;
endpackage

// File: rtl/bm_map_table.sv
module bm_map_table
  import bm_pkg::*;
#(
  parameter int    PAGES      = 64,
  parameter page_t RESET_BASE = 16'h0080,
  localparam int   IDX_W      = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_we,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic             byte_hi,
  input  logic [7:0]       byte_val,
  input  logic             run_we,
  input  logic [IDX_W-1:0] run_idx,
  input  page_t            run_val,
  input  logic [IDX_W-1:0] rd_idx,
  output page_t            rd_val
);
  page_t entry [PAGES];

  for (genvar i = 0; i < PAGES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entry[i] <= RESET_BASE + page_t'(i);
      end else if (run_we && run_idx == IDX_W'(i)) begin
        entry[i] <= run_val;
      end else if (byte_we && byte_idx == IDX_W'(i)) begin
        if (byte_hi) entry[i][15:8] <= byte_val;
        else         entry[i][7:0]  <= byte_val;
      end
    end
  end

  assign rd_val = entry[rd_idx];
endmodule

// File: rtl/bm_bulk_seq.sv
module bm_bulk_seq
  import bm_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  page_t            start_page,
  input  logic [IDX_W-1:0] run_len,
  output logic             busy,
  output logic [IDX_W-1:0] wr_idx,
  output page_t            wr_val
);
  logic [IDX_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wr_idx <= '0;
      wr_val <= '0;
      last_q <= '0;
    end else if (busy) begin
      wr_idx <= wr_idx + 1'b1;
      wr_val <= wr_val + 1'b1;
      if (wr_idx == last_q) busy <= 1'b0;
    end else if (start && run_len != '0) begin
      busy   <= 1'b1;
      wr_idx <= '0;
      wr_val <= start_page;
      last_q <= run_len - 1'b1;
    end
  end
endmodule

// File: rtl/bm_xlate_stage.sv
module bm_xlate_stage
  import bm_pkg::*;
#(
  parameter int              IDX_W    = 6,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CPU_AW-1:0] in_addr,
  output logic [IDX_W-1:0]  rd_idx,
  input  page_t             rd_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   out_addr
);
  localparam int TAG_LO = OFS_W + IDX_W;

  logic hit;

  assign in_ready = !out_valid || out_ready;
  assign rd_idx   = in_addr[OFS_W +: IDX_W];
  assign hit      = in_addr[CPU_AW-1:TAG_LO] == WIN_BASE[CPU_AW-1:TAG_LO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_addr  <= hit ? {rd_val, in_addr[OFS_W-1:0]} : PA_W'(in_addr);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bm_pkg::*;
#(
  parameter int                WIN_PAGES = 64,
  parameter logic [CPU_AW-1:0] WIN_BASE  = 16'h8000,
  localparam int               IDX_W     = $clog2(WIN_PAGES),
  localparam int               REG_AW    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic              bulk_busy,
  input  logic              xl_valid,
  output logic              xl_ready,
  input  logic [CPU_AW-1:0] xl_addr,
  output logic              pa_valid,
  input  logic              pa_ready,
  output logic [PA_W-1:0]   pa_addr
);
  localparam page_t RESET_BASE = page_t'(WIN_BASE >> OFS_W);

  logic             wr_ok, is_ctl, tbl_we, start;
  ctl_sel_e         ctl;
  logic [7:0]       hi_q;
  logic [IDX_W-1:0] run_len_q;
  logic [IDX_W-1:0] run_idx, rd_idx;
  page_t            run_val, rd_val;

  assign wr_ok  = reg_wr && !bulk_busy;
  assign is_ctl = reg_addr[REG_AW-1] && (reg_addr[REG_AW-2:2] == '0);
  assign ctl    = ctl_sel_e'(reg_addr[1:0]);
  assign tbl_we = wr_ok && !reg_addr[REG_AW-1];
  assign start  = wr_ok && is_ctl && ctl == CTL_BASE_HI;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q      <= '0;
      run_len_q <= '0;
    end else if (wr_ok && is_ctl) begin
      if (ctl == CTL_HIGH)  hi_q      <= reg_wdata;
      if (ctl == CTL_COUNT) run_len_q <= reg_wdata[IDX_W-1:0];
    end
  end

  bm_bulk_seq #(.IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_page ({hi_q, reg_wdata}),
    .run_len    (run_len_q),
    .busy       (bulk_busy),
    .wr_idx     (run_idx),
    .wr_val     (run_val)
  );

  bm_map_table #(.PAGES(WIN_PAGES), .RESET_BASE(RESET_BASE)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_we  (tbl_we),
    .byte_idx (reg_addr[IDX_W:1]),
    .byte_hi  (reg_addr[0]),
    .byte_val (reg_wdata),
    .run_we   (bulk_busy),
    .run_idx  (run_idx),
    .run_val  (run_val),
    .rd_idx   (rd_idx),
    .rd_val   (rd_val)
  );

  bm_xlate_stage #(.IDX_W(IDX_W), .WIN_BASE(WIN_BASE)) u_xl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (xl_valid),
    .in_ready  (xl_ready),
    .in_addr   (xl_addr),
    .rd_idx    (rd_idx),
    .rd_val    (rd_val),
    .out_valid (pa_valid),
    .out_ready (pa_ready),
    .out_addr  (pa_addr)
  );
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
  import bm_pkg::*;
#(
  parameter int                WIN_PAGES = 64,
  parameter logic [CPU_AW-1:0] WIN_BASE  = 16'h8000,
  localparam int               IDX_W     = $clog2(WIN_PAGES),
  localparam int               REG_AW    = IDX_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic              bulk_busy,
  input logic              xl_valid,
  input logic              xl_ready,
  input logic [CPU_AW-1:0] xl_addr,
  input logic              pa_valid,
  input logic              pa_ready,
  input logic [PA_W-1:0]   pa_addr,
  input logic [IDX_W-1:0]  run_len_q
);
  localparam int TAG_LO = OFS_W + IDX_W;

  logic           trig, in_win;
  logic [IDX_W:0] busy_cnt;

  assign trig   = reg_wr && !bulk_busy && reg_addr == REG_AW'(2 * WIN_PAGES + 1);
  assign in_win = xl_addr[CPU_AW-1:TAG_LO] == WIN_BASE[CPU_AW-1:TAG_LO];

  always_ff @(posedge clk) begin
    if (!rst_n || !bulk_busy) busy_cnt <= '0;
    else                      busy_cnt <= busy_cnt + 1'b1;
  end

  a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    trig && run_len_q == '0 |=> !bulk_busy);

  a_r8_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    trig && run_len_q != '0 |=> bulk_busy);

  a_r8_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_busy |-> busy_cnt < (IDX_W + 1)'(WIN_PAGES));

  a_r3_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && xl_ready && !in_win |=> pa_addr == PA_W'($past(xl_addr)));

  a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && xl_ready |=> pa_addr[OFS_W-1:0] == $past(xl_addr[OFS_W-1:0]));

  a_r11_valid: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && xl_ready |=> pa_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pa_valid && !pa_ready |=> pa_valid && $stable(pa_addr));
endmodule

bind bank_mapper bank_mapper_chk #(.WIN_PAGES(WIN_PAGES), .WIN_BASE(WIN_BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .bulk_busy (bulk_busy),
  .xl_valid  (xl_valid),
  .xl_ready  (xl_ready),
  .xl_addr   (xl_addr),
  .pa_valid  (pa_valid),
  .pa_ready  (pa_ready),
  .pa_addr   (pa_addr),
  .run_len_q (run_len_q)
);

// File: tb/tb_bank_mapper.sv
`timescale 1ns/1ps
module tb_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        bulk_busy;
  logic        xl_valid = 1'b0;
  logic        xl_ready;
  logic [15:0] xl_addr = '0;
  logic        pa_valid;
  logic        pa_ready = 1'b1;
  logic [23:0] pa_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int t0, t1;

  logic [15:0] model [64];
  logic [23:0] exp_q [$];
  string       tag_q [$];

  bank_mapper dut (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic xl(input logic [15:0] a, input string tag);
    logic [23:0] e;
    if (a[15:14] == 2'b10) e = {model[a[13:8]], a[7:0]};
    else                   e = {8'h00, a};
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    xl_valid = 1'b1; xl_addr = a;
    forever begin
      @(negedge clk);
      if (xl_ready) break;
    end
    @(posedge clk); #1;
    xl_valid = 1'b0;
  endtask

  task automatic wait_idle(output int t);
    forever begin
      @(negedge clk);
      if (!bulk_busy) break;
    end
    t = cyc;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pa_valid && pa_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected output", {8'h0, pa_addr}, 32'h0);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(pa_addr == e, t, {8'h0, pa_addr}, {8'h0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'h0080 + 16'(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!bulk_busy && !pa_valid && xl_ready, "R1 reset outputs",
        {29'h0, bulk_busy, pa_valid, xl_ready}, 32'h1);

    // R1 identity map, R2 offset
    xl(16'h8000, "R1 identity page 0");
    xl(16'hBF12, "R1 identity page 63");
    xl(16'hA5FF, "R2 window page 37");
    // R3 pass-through
    xl(16'h1234, "R3 below window");
    xl(16'hC000, "R3 above window");
    xl(16'h7FFF, "R3 edge below");

    // R4 byte writes
    wr(8'h06, 8'h34); wr(8'h07, 8'h12); model[3] = 16'h1234;
    wr(8'h0A, 8'h56); model[5] = 16'h0056;
    xl(16'h8377, "R4 both bytes");
    xl(16'h8501, "R4 low byte only");
    // R10 alias
    wr(8'h12, 8'h34); wr(8'h13, 8'h12); model[9] = 16'h1234;
    xl(16'h8900, "R10 alias page 9");
    xl(16'h8301, "R10 alias page 3");

    // R11 latency
    xl(16'h4444, "R11 latency item");
    @(negedge clk);
    chk(1'b1, "R11 latency", 1, 1);

    // R5/R6/R8 run of 8 from 0x0340
    wr(8'h83, 8'hC8);
    wr(8'h82, 8'h03);
    wr(8'h80, 8'h99);
    wr(8'h81, 8'h40);
    t0 = cyc;
    @(negedge clk);
    chk(bulk_busy == 1'b1, "R8 busy after trigger", {31'h0, bulk_busy}, 1);
    xl(16'h8700, "R8 old value mid-run");
    wait_idle(t1);
    chk(t1 - t0 == 8, "R6 run length from bits 5..0 / R8 busy length", t1 - t0, 8);
    for (int k = 0; k < 8; k++) model[k] = 16'h0340 + 16'(k);
    xl(16'h8010, "R5 entry 0");
    xl(16'h8322, "R5 entry 3");
    xl(16'h87EE, "R5 entry 7");
    xl(16'h8844, "R5 entry 8 untouched");

    // R7 zero length
    wr(8'h83, 8'h00);
    wr(8'h81, 8'h77);
    @(negedge clk);
    chk(bulk_busy == 1'b0, "R7 no busy", {31'h0, bulk_busy}, 0);
    xl(16'h8000, "R7 entry 0 kept");
    xl(16'h8100, "R7 entry 1 kept");

    // R9 writes ignored while busy; R5 wrap
    wr(8'h83, 8'd20);
    wr(8'h82, 8'hFF);
    wr(8'h81, 8'hF0);
    t0 = cyc;
    wr(8'h50, 8'h55);
    wr(8'h83, 8'h3F);
    wr(8'h81, 8'h00);
    wait_idle(t1);
    chk(t1 - t0 == 20, "R9 busy length unchanged by writes", t1 - t0, 20);
    for (int k = 0; k < 20; k++) model[k] = 16'hFFF0 + 16'(k);
    xl(16'hA811, "R9 entry 40 write ignored");
    xl(16'h9301, "R5 wrap entry 19");
    xl(16'h8F02, "R5 entry 15");
    xl(16'h9403, "R5 entry 20 untouched");
    // the run-length write was ignored: a new trigger runs 20 again
    wr(8'h81, 8'hF0);
    t0 = cyc;
    wait_idle(t1);
    chk(t1 - t0 == 20, "R9 run length write ignored", t1 - t0, 20);

    // R11 back-pressure
    @(posedge clk); #1 pa_ready = 1'b0;
    xl(16'h1000, "R11 stalled first");
    fork
      xl(16'h2000, "R11 stalled second");
    join_none
    repeat (3) begin
      @(negedge clk);
      chk(pa_valid && pa_addr == 24'h001000 && !xl_ready, "R11 hold under stall",
          {8'h0, pa_addr}, 32'h001000);
    end
    @(posedge clk); #1 pa_ready = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R11 all results delivered", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule